// File: doc/BRIEF.md
# Pad Pull Resistor Programming Sequencer

This block keeps the pull-resistor setting of every pad in a bank of general-purpose pins and drives that setting to the pads. Software cannot write a pin's pull state directly, and it cannot read it back. Instead it loads the wanted pull mode into a shared mode register. After a settle time it sets the pin's bit in a per-bank strobe word. That 0-to-1 transition copies the mode into the pin's two-bit pull latch, but only if the mode has held still for long enough. A strobe that comes too early is dropped and raises a sticky error flag.

A small built-in sequencer runs the whole procedure for a single pin. Given a start pulse, a pin number and a mode, it writes the mode, waits the settle time, sets the strobe bit, waits again, and then clears the strobe word. It holds busy for the whole run and pulses done once at the end. While the sequencer runs it owns the register write path.

Top module: `pad_pull_ctrl`

## Requirements
- R1: After reset, every pull latch holds 0 (off) and strobe_err is 0. The mode register and both strobe words read 0, and seq_busy and seq_done are 0.
- R2: The mode register is at byte address 0x94 and keeps only bits [1:0] of a write. A read returns those two bits with every other bit 0.
- R3: Strobe words sit at 0x98 (pins 0 to 31) and 0x9C (pins 32 to 53). Pin p is bit p%32 of word 0x98+4*(p/32). Both words read back, and bits with no pin read 0.
- R4: Mode codes are 0 = off, 1 = pull-down and 2 = pull-up. Pin p drives pull_state[2p+1:2p]. A 0-to-1 write of a pin's strobe bit loads the mode into that pin's latch at the same clock edge, provided the edge comes at least SETTLE_CYCLES (150) clock edges after the last mode write edge or after reset release.
- R5: A 0-to-1 strobe that comes sooner than that leaves every latch unchanged and sets strobe_err. strobe_err then stays set until reset.
- R6: An accepted strobe while the mode register holds 3 (reserved) leaves the latch unchanged.
- R7: Writing 1 to a strobe bit that already holds 1 loads nothing.
- R8: No address returns pull state. Every address other than the mode register and the two strobe words reads 0.
- R9: A seq_start while idle runs the full sequence: write the mode, wait, set the strobe bit, wait, clear the strobe word. The pin's latch then holds the mode, and both strobe words read 0. seq_busy stays high throughout without setting strobe_err, and seq_done is a one-cycle pulse in the first cycle after seq_busy falls.
- R10: While seq_busy is high, seq_start and writes on the register port are ignored.
- R11: A sequencer run for a pin number of 54 or above changes no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| seq_start | input | 1 | Start one sequencer run |
| seq_pin | input | 6 | Pin number for the run |
| seq_mode | input | 2 | Pull mode for the run |
| seq_busy | output | 1 | Sequencer run in progress |
| seq_done | output | 1 | One-cycle end-of-run pulse |
| pull_state | output | 108 | Two bits of pull mode per pin, pin p at [2p+1:2p] |
| strobe_err | output | 1 | Sticky: a strobe arrived before the mode had settled |

## Verification
On every cycle the assertions check the following: the settle counter saturation, that a strobe either loads the mode or, when early, holds all latches and raises the sticky error, that reserved mode holds the latch, and the busy and done handshake of the sequencer. Only the bench scenarios can show the exact settle boundary, one edge too early versus just in time. They also cover the strobe-word address decode and readback, the masking of foreign writes and starts during a run, the out-of-range pin case, and a sweep of every pin through the sequencer against a model of all 54 latches.

// File: rtl/pull_pkg.sv
package pull_pkg;
    localparam int PULL_MODE_OFS = 'h94;
    localparam int PULL_STRB_OFS = 'h98;

    typedef enum logic [1:0] {
        PULL_OFF  = 2'd0,
        PULL_DOWN = 2'd1,
        PULL_UP   = 2'd2,
        PULL_RSVD = 2'd3
    } pull_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_MODE,
        SQ_WAIT_SET,
        SQ_SET,
        SQ_WAIT_CLR,
        SQ_CLR
    } seq_state_e;
endpackage

// File: rtl/pull_regfile.sv
module pull_regfile
    import pull_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int SETTLE   = 150,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic [1:0]          mode,
    output logic [NUM_PINS-1:0] strb_rise,
    output logic                settled
);
    localparam int CNT_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [1:0]          mode;
        logic [NUM_PINS-1:0] strb;
        logic [CNT_W-1:0]    cnt;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (rf_q.cnt < CNT_W'(SETTLE)) begin
            rf_d.cnt = rf_q.cnt + 1'b1;
        end
        if (wr_en && wr_addr == ADDR_W'(PULL_MODE_OFS)) begin
            rf_d.mode = wr_data[1:0];
            rf_d.cnt  = '0;
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            if (wr_en && wr_addr == ADDR_W'(PULL_STRB_OFS + 4 * (p / DATA_W))) begin
                rf_d.strb[p] = wr_data[p % DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(PULL_MODE_OFS)) begin
            rd_data[1:0] = rf_q.mode;
        end
        for (int p = 0; p < NUM_PINS; p++) begin
            if (rd_addr == ADDR_W'(PULL_STRB_OFS + 4 * (p / DATA_W))) begin
                rd_data[p % DATA_W] = rf_q.strb[p];
            end
        end
    end

    assign mode      = rf_q.mode;
    assign strb_rise = rf_d.strb & ~rf_q.strb;
    assign settled   = (rf_q.cnt >= CNT_W'(SETTLE - 1));

    // R4: settle counter never runs past its saturation value
    a_r4_settle_sat: assert property (@(posedge clk) disable iff (!rst_n)
        rf_q.cnt <= CNT_W'(SETTLE));

    // R2: a mode write keeps only its two low bits
    a_r2_mode_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(PULL_MODE_OFS)) |=> mode == $past(wr_data[1:0]));

    // R5: a mode write restarts the settle window
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(PULL_MODE_OFS)) |=> !settled);
endmodule

// File: rtl/pull_latch_array.sv
module pull_latch_array
    import pull_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   strb_rise,
    input  logic                  settled,
    input  logic [1:0]            mode,
    output logic [2*NUM_PINS-1:0] pull,
    output logic                  err
);
    logic err_d, err_q;
    logic load_ok;

    assign load_ok = settled && (pull_mode_e'(mode) != PULL_RSVD);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [1:0] lat_d, lat_q;

        always_comb begin
            lat_d = lat_q;
            if (strb_rise[p] && load_ok) begin
                lat_d = mode;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lat_q <= 2'd0;
            end else begin
                lat_q <= lat_d;
            end
        end

        assign pull[2*p +: 2] = lat_q;

        // R4: accepted strobe loads the mode into this pin
        a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
            (strb_rise[p] && settled && mode != 2'd3) |=> pull[2*p +: 2] == $past(mode));

        // R6: reserved mode leaves the latch as it was
        a_r6_rsvd_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (strb_rise[p] && mode == 2'd3) |=> $stable(pull[2*p +: 2]));
    end

    always_comb begin
        err_d = err_q;
        if (|strb_rise && !settled) begin
            err_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err = err_q;

    // R5: early strobe changes no latch and raises the error
    a_r5_early_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (|strb_rise && !settled) |=> ($stable(pull) && err));

    // R5: error is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/pull_seq.sv
module pull_seq
    import pull_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int SETTLE   = 150,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int PIN_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIN_W-1:0]  pin,
    input  logic [1:0]        mode,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    localparam int WCNT_W = $clog2(SETTLE + 1);

    typedef struct packed {
        seq_state_e        st;
        logic [PIN_W-1:0]  pin;
        logic [1:0]        mode;
        logic [WCNT_W-1:0] wcnt;
        logic              done;
    } sq_t;

    sq_t sq_d, sq_q;
    logic [ADDR_W-1:0] strb_addr;

    assign strb_addr = ADDR_W'(PULL_STRB_OFS + 4 * (int'(sq_q.pin) / DATA_W));

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = '0;
        wr_data   = '0;
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    sq_d.st   = SQ_MODE;
                    sq_d.pin  = pin;
                    sq_d.mode = mode;
                end
            end
            SQ_MODE: begin
                wr_en        = 1'b1;
                wr_addr      = ADDR_W'(PULL_MODE_OFS);
                wr_data[1:0] = sq_q.mode;
                sq_d.st      = SQ_WAIT_SET;
                sq_d.wcnt    = '0;
            end
            SQ_WAIT_SET: begin
                sq_d.wcnt = sq_q.wcnt + 1'b1;
                if (sq_q.wcnt == WCNT_W'(SETTLE - 1)) begin
                    sq_d.st = SQ_SET;
                end
            end
            SQ_SET: begin
                wr_en     = 1'b1;
                wr_addr   = strb_addr;
                wr_data   = DATA_W'(1) << (int'(sq_q.pin) % DATA_W);
                sq_d.st   = SQ_WAIT_CLR;
                sq_d.wcnt = '0;
            end
            SQ_WAIT_CLR: begin
                sq_d.wcnt = sq_q.wcnt + 1'b1;
                if (sq_q.wcnt == WCNT_W'(SETTLE - 1)) begin
                    sq_d.st = SQ_CLR;
                end
            end
            SQ_CLR: begin
                wr_en     = 1'b1;
                wr_addr   = strb_addr;
                sq_d.st   = SQ_IDLE;
                sq_d.done = 1'b1;
            end
            default: sq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q <= '{st: SQ_IDLE, pin: '0, mode: '0, wcnt: '0, done: 1'b0};
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy = (sq_q.st != SQ_IDLE);
    assign done = sq_q.done;

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: start while idle makes the sequencer busy
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9: end of busy coincides with done
    a_r9_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: a start during a run does not replace the captured request
    a_r10_start_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(sq_q.pin) && $stable(sq_q.mode)));
endmodule

// File: rtl/pad_pull_ctrl.sv
module pad_pull_ctrl
    import pull_pkg::*;
#(
    parameter int NUM_PINS      = 54,
    parameter int SETTLE_CYCLES = 150,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32,
    parameter int PIN_W         = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic                  seq_start,
    input  logic [PIN_W-1:0]      seq_pin,
    input  logic [1:0]            seq_mode,
    output logic                  seq_busy,
    output logic                  seq_done,
    output logic [2*NUM_PINS-1:0] pull_state,
    output logic                  strobe_err
);
    logic              sq_wr_en;
    logic [ADDR_W-1:0] sq_wr_addr;
    logic [DATA_W-1:0] sq_wr_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [1:0]            mode;
    logic [NUM_PINS-1:0]   strb_rise;
    logic                  settled;

    pull_seq #(
        .NUM_PINS(NUM_PINS), .SETTLE(SETTLE_CYCLES),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PIN_W(PIN_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(seq_start), .pin(seq_pin), .mode(seq_mode),
        .wr_en(sq_wr_en), .wr_addr(sq_wr_addr), .wr_data(sq_wr_data),
        .busy(seq_busy), .done(seq_done)
    );

    assign wr_en   = seq_busy ? sq_wr_en   : reg_wr;
    assign wr_addr = seq_busy ? sq_wr_addr : reg_addr;
    assign wr_data = seq_busy ? sq_wr_data : reg_wdata;

    pull_regfile #(
        .NUM_PINS(NUM_PINS), .SETTLE(SETTLE_CYCLES),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(reg_addr), .rd_data(reg_rdata),
        .mode(mode), .strb_rise(strb_rise), .settled(settled)
    );

    pull_latch_array #(
        .NUM_PINS(NUM_PINS)
    ) u_lat (
        .clk(clk), .rst_n(rst_n),
        .strb_rise(strb_rise), .settled(settled), .mode(mode),
        .pull(pull_state), .err(strobe_err)
    );
endmodule

// File: tb/pad_pull_ctrl_tb_top.sv
module pad_pull_ctrl_tb_top;
    localparam int NP = 54;
    localparam int ST = 150;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_start = 1'b0;
    logic [5:0]  seq_pin = '0;
    logic [1:0]  seq_mode = '0;
    logic        seq_busy, seq_done;
    logic [2*NP-1:0] pull_state;
    logic        strobe_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] exp_pull [NP];

    always #4 clk = ~clk;

    pad_pull_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_start(seq_start), .seq_pin(seq_pin), .seq_mode(seq_mode),
        .seq_busy(seq_busy), .seq_done(seq_done),
        .pull_state(pull_state), .strobe_err(strobe_err)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2*NP-1:0] exp_vec();
        logic [2*NP-1:0] v;
        for (int p = 0; p < NP; p++) v[2*p +: 2] = exp_pull[p];
        return v;
    endfunction

    task automatic chk_pull(input string tag);
        chk(tag, 128'(pull_state), 128'(exp_vec()));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < NP; p++) exp_pull[p] = 2'd0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_seq(input int pin, input logic [1:0] m, input bit busy_poke);
        int guard;
        @(negedge clk);
        seq_start = 1'b1; seq_pin = 6'(pin); seq_mode = m;
        @(negedge clk);
        seq_start = 1'b0;
        chk("R9 busy after start", 128'(seq_busy), 128'(1));
        if (busy_poke) begin
            // R10: foreign start and register writes during the run
            seq_start = 1'b1; seq_pin = 6'(pin + 1); seq_mode = ~m;
            @(negedge clk);
            seq_start = 1'b0;
            wr(8'h94, 32'(~m));
            wr(8'h98, 32'hFFFF_FFFF);
        end
        guard = 0;
        while (!seq_done && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        chk("R9 done seen", 128'(seq_done), 128'(1));
        chk("R9 busy low at done", 128'(seq_busy), 128'(0));
        @(negedge clk);
        chk("R9 done one cycle", 128'(seq_done), 128'(0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        do_reset();
        // R1 reset state
        chk_pull("R1 pulls off");
        chk("R1 err clear", 128'(strobe_err), 128'(0));
        chk("R1 idle", 128'({seq_busy, seq_done}), 128'(0));
        rd(8'h94, d); chk("R1 mode reads 0", 128'(d), 128'(0));
        rd(8'h98, d); chk("R1 strobe0 reads 0", 128'(d), 128'(0));
        rd(8'h9C, d); chk("R1 strobe1 reads 0", 128'(d), 128'(0));

        // R2 mode register keeps two bits; R5 early strobe
        wr(8'h94, 32'hFFFF_FFF6);
        rd(8'h94, d); chk("R2 mode readback", 128'(d), 128'(2));
        wr(8'h94, 32'h0000_0002);
        repeat (ST - 3) @(negedge clk);
        wr(8'h98, 32'h0000_0020);
        chk_pull("R5 early strobe ignored");
        chk("R5 err set", 128'(strobe_err), 128'(1));
        wr(8'h98, 32'h0);
        repeat (200) @(negedge clk);
        chk("R5 err sticky", 128'(strobe_err), 128'(1));

        // R4 strobe exactly at the settle boundary
        do_reset();
        wr(8'h94, 32'h1);
        repeat (ST - 2) @(negedge clk);
        wr(8'h98, 32'h0000_0080);
        exp_pull[7] = 2'd1;
        chk_pull("R4 load at boundary");
        chk("R4 no err", 128'(strobe_err), 128'(0));
        rd(8'h98, d); chk("R3 strobe0 readback", 128'(d), 128'(32'h80));

        // R7 rewriting an already-set bit
        wr(8'h94, 32'h2);
        repeat (ST + 10) @(negedge clk);
        wr(8'h98, 32'h0000_0080);
        chk_pull("R7 no load without 0-to-1");
        wr(8'h98, 32'h0);
        wr(8'h98, 32'h0000_0080);
        exp_pull[7] = 2'd2;
        chk_pull("R4 reload pull-up");

        // R3 upper bank and unused bits
        wr(8'h9C, 32'hFFFF_FFFF);
        for (int p = 32; p < NP; p++) exp_pull[p] = 2'd2;
        chk_pull("R3 bank1 pins loaded");
        rd(8'h9C, d); chk("R3 bank1 readback masked", 128'(d), 128'(32'h003F_FFFF));

        // R8 no other readable address
        rd(8'h90, d); chk("R8 addr 0x90 reads 0", 128'(d), 128'(0));
        rd(8'hA0, d); chk("R8 addr 0xA0 reads 0", 128'(d), 128'(0));
        rd(8'h00, d); chk("R8 addr 0x00 reads 0", 128'(d), 128'(0));

        // R6 reserved mode
        wr(8'h9C, 32'h0);
        wr(8'h98, 32'h0);
        wr(8'h94, 32'h3);
        repeat (ST + 10) @(negedge clk);
        wr(8'h98, 32'hFFFF_FFFF);
        wr(8'h9C, 32'hFFFF_FFFF);
        chk_pull("R6 reserved no change");
        chk("R5 no err with settled strobes", 128'(strobe_err), 128'(0));

        // R9 sequencer sweep over every pin
        do_reset();
        for (int p = 0; p < NP; p++) begin
            logic [1:0] m;
            m = 2'((p * 7 + 1) % 3);
            run_seq(p, m, 1'b0);
            exp_pull[p] = m;
            chk_pull("R9 sweep pull vector");
        end
        rd(8'h98, d); chk("R9 strobe0 cleared", 128'(d), 128'(0));
        rd(8'h9C, d); chk("R9 strobe1 cleared", 128'(d), 128'(0));
        chk("R9 no err", 128'(strobe_err), 128'(0));

        // R10 foreign start and writes during a run are ignored
        run_seq(3, 2'd2, 1'b1);
        exp_pull[3] = 2'd2;
        chk_pull("R10 run result only");
        rd(8'h94, d); chk("R10 mode from sequencer", 128'(d), 128'(2));
        rd(8'h98, d); chk("R10 strobe write dropped", 128'(d), 128'(0));

        // R11 out-of-range pin
        run_seq(60, 2'd1, 1'b0);
        chk_pull("R11 pin 60 no change");
        run_seq(63, 2'd2, 1'b0);
        chk_pull("R11 pin 63 no change");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule